// File: doc/BRIEF.md
# Timestamped Interlock Aggregator

This block gathers every protection source of a radio-frequency station controller into a single trip decision. Nine fast RF channels supply digitized IF samples, and each of them faults when the sample magnitude rises above a per-channel limit. Eight slow baseband channels supply converter codes, and each of them faults when the code leaves a per-channel acceptance window. The external interlock line is fail-safe. A high level permits operation, so a low level, including an unplugged cable, counts as a fault. Any fault trips the station. The trip forces the DAC drive to zero and pulls the interlock output low.

Each source has a sticky fault flag, a captured timestamp and the value that caused the fault. The timestamp comes from a free-running tick counter supplied from outside. The block also builds a short event list: the first trips in time order, each with its delay after the first one. A clear request releases all of this state, but only in a cycle where no source is faulting.

Top module: `ilk_aggregator`

## Requirements
- R1: After reset no channel is flagged, `trip` and `dac_zero` are low, `ilk_out` is high, the event count is zero, and all captured fields read zero.
- R2: An RF channel (signed two's complement sample) faults when its valid strobe is high and the sample's absolute value is strictly greater than its unsigned threshold. A magnitude equal to the threshold does not fault. The most negative code has magnitude 2^(RF_W-1).
- R3: A sample whose valid strobe is low is ignored. It sets no flag and records no event.
- R4: A baseband channel faults when its valid strobe is high and its unsigned code is below its low limit or above its high limit. Both limits are themselves accepted values, so a low limit of 0 or a high limit of full scale disables that side.
- R5: A low level on `ext_ok` faults the external channel in every cycle it is sampled.
- R6: `trip` and `dac_zero` go high, and `ilk_out` goes low, on the clock edge that samples the first fault. They stay so while any channel flag is set.
- R7: On its first fault a channel latches its flag, the timestamp present at that edge and the offending value. RF values are sign-extended and baseband values zero-extended to VAL_W; the external channel stores 0. None of these change on later faults until cleared.
- R8: `clr` clears all flags, captured fields and the event list only in a cycle in which no channel faults. Otherwise it is ignored.
- R9: Channel indices are 0..N_RF-1 for RF, N_RF..N_RF+N_BB-1 for baseband, and N_RF+N_BB for the external line. Newly faulting channels are appended to the event list in time order. Channels first faulting in the same cycle are appended in ascending index.
- R10: Each event's delay field is its timestamp minus the timestamp of event 0, taken modulo 2^TS_W. Event 0 therefore reads 0.
- R11: At most N_EVT events are recorded. Later first faults still set their flags but leave the list and its count unchanged. Unused list slots read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Request to release latched state |
| rf_sample | input | N_RF*RF_W | Signed IF samples, channel i at bits i*RF_W |
| rf_valid | input | N_RF | New-sample strobes for RF channels |
| rf_thresh | input | N_RF*RF_W | Unsigned magnitude limits |
| bb_value | input | N_BB*BB_W | Unsigned baseband codes |
| bb_valid | input | N_BB | New-sample strobes for baseband channels |
| bb_lo | input | N_BB*BB_W | Lowest accepted baseband code |
| bb_hi | input | N_BB*BB_W | Highest accepted baseband code |
| ext_ok | input | 1 | External permit, high allows operation |
| timestamp | input | TS_W | Free-running tick counter |
| trip | output | 1 | Station tripped |
| dac_zero | output | 1 | Force DAC drive to zero |
| ilk_out | output | 1 | Chained interlock level, high when permitted |
| ch_fault | output | NCH | Sticky per-channel flags |
| ch_time | output | NCH*TS_W | Captured trip timestamps |
| ch_value | output | NCH*VAL_W | Captured offending values |
| evt_ch | output | N_EVT*IDX_W | Channel index per event slot |
| evt_dt | output | N_EVT*TS_W | Delay of each event after event 0 |
| evt_cnt | output | CNT_W | Number of recorded events |

## Verification
A comparator boundary that is off by one shows up on the edge that samples the boundary value. A flag appears where none was expected, or is missing, and `trip` and `ilk_out` move with it. A latch that fails to hold shows up one edge after a repeated fault, because the timestamp or value changes. A clear that is gated wrongly is visible on the edge after the request. A wrong ordering rule or a wrong base time is visible in the event slots on the same edge that records the events. The bench compares every output after every clock edge against an arithmetic model, so any of these faults is reported within one cycle of its cause.

// File: rtl/ilk_rf_det.sv
module ilk_rf_det #(
  parameter int W = 16
) (
  input  logic [W-1:0] sample,
  input  logic         valid,
  input  logic [W-1:0] thresh,
  output logic         hit
);
  logic [W:0] mag;

  always_comb begin
    if (sample[W-1]) mag = {1'b0, ~sample} + {{W{1'b0}}, 1'b1};
    else             mag = {1'b0, sample};
    hit = valid && (mag > {1'b0, thresh});
  end
endmodule

// File: rtl/ilk_bb_det.sv
module ilk_bb_det #(
  parameter int W = 12
) (
  input  logic [W-1:0] value,
  input  logic         valid,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         hit
);
  always_comb hit = valid && ((value < lo) || (value > hi));
endmodule

// File: rtl/ilk_ch_latch.sv
module ilk_ch_latch #(
  parameter int TS_W  = 32,
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             clr,
  input  logic [TS_W-1:0]  ts,
  input  logic [VAL_W-1:0] val,
  output logic             flag_q,
  output logic [TS_W-1:0]  ts_q,
  output logic [VAL_W-1:0] val_q
);
  logic             flag_d;
  logic [TS_W-1:0]  ts_d;
  logic [VAL_W-1:0] val_d;
  logic             en;

  always_comb begin
    flag_d = flag_q;
    ts_d   = ts_q;
    val_d  = val_q;
    en     = 1'b0;
    if (clr) begin
      en     = 1'b1;
      flag_d = 1'b0;
      ts_d   = '0;
      val_d  = '0;
    end else if (hit && !flag_q) begin
      en     = 1'b1;
      flag_d = 1'b1;
      ts_d   = ts;
      val_d  = val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ts_q   <= '0;
      val_q  <= '0;
    end else if (en) begin
      flag_q <= flag_d;
      ts_q   <= ts_d;
      val_q  <= val_d;
    end
  end

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> (flag_q && $stable(ts_q) && $stable(val_q)));

  // R2
  hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr) |=> flag_q);
endmodule

// File: rtl/ilk_evt_seq.sv
module ilk_evt_seq #(
  parameter int NCH   = 18,
  parameter int N_EVT = 10,
  parameter int TS_W  = 32,
  localparam int IDX_W = $clog2(NCH),
  localparam int CNT_W = $clog2(N_EVT + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic [NCH-1:0]         newhit,
  input  logic [TS_W-1:0]        ts,
  output logic [N_EVT*IDX_W-1:0] evt_ch,
  output logic [N_EVT*TS_W-1:0]  evt_dt,
  output logic [CNT_W-1:0]       evt_cnt
);
  logic [IDX_W-1:0] ch_q [N_EVT];
  logic [IDX_W-1:0] ch_d [N_EVT];
  logic [TS_W-1:0]  dt_q [N_EVT];
  logic [TS_W-1:0]  dt_d [N_EVT];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TS_W-1:0]  t0_q, t0_d;
  logic             en;

  always_comb begin
    for (int k = 0; k < N_EVT; k++) begin
      ch_d[k] = ch_q[k];
      dt_d[k] = dt_q[k];
    end
    cnt_d = cnt_q;
    t0_d  = t0_q;
    en    = clr || (|newhit);
    if (clr) begin
      for (int k = 0; k < N_EVT; k++) begin
        ch_d[k] = '0;
        dt_d[k] = '0;
      end
      cnt_d = '0;
      t0_d  = '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (newhit[c] && (cnt_d < CNT_W'(N_EVT))) begin
          if (cnt_d == '0) t0_d = ts;
          ch_d[int'(cnt_d)] = IDX_W'(c);
          dt_d[int'(cnt_d)] = ts - t0_d;
          cnt_d = cnt_d + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_EVT; k++) begin
        ch_q[k] <= '0;
        dt_q[k] <= '0;
      end
      cnt_q <= '0;
      t0_q  <= '0;
    end else if (en) begin
      for (int k = 0; k < N_EVT; k++) begin
        ch_q[k] <= ch_d[k];
        dt_q[k] <= dt_d[k];
      end
      cnt_q <= cnt_d;
      t0_q  <= t0_d;
    end
  end

  for (genvar k = 0; k < N_EVT; k++) begin : g_flat
    assign evt_ch[k*IDX_W +: IDX_W] = ch_q[k];
    assign evt_dt[k*TS_W +: TS_W]   = dt_q[k];
  end
  assign evt_cnt = cnt_q;

  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(N_EVT));

  // R9
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q >= $past(cnt_q)));

  // R10
  first_dt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (dt_q[0] == '0));
endmodule

// File: rtl/ilk_aggregator.sv
module ilk_aggregator #(
  parameter int N_RF  = 9,
  parameter int N_BB  = 8,
  parameter int RF_W  = 16,
  parameter int BB_W  = 12,
  parameter int TS_W  = 32,
  parameter int N_EVT = 10,
  localparam int NCH   = N_RF + N_BB + 1,
  localparam int VAL_W = (RF_W > BB_W) ? RF_W : BB_W,
  localparam int IDX_W = $clog2(NCH),
  localparam int CNT_W = $clog2(N_EVT + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic [N_RF*RF_W-1:0]   rf_sample,
  input  logic [N_RF-1:0]        rf_valid,
  input  logic [N_RF*RF_W-1:0]   rf_thresh,
  input  logic [N_BB*BB_W-1:0]   bb_value,
  input  logic [N_BB-1:0]        bb_valid,
  input  logic [N_BB*BB_W-1:0]   bb_lo,
  input  logic [N_BB*BB_W-1:0]   bb_hi,
  input  logic                   ext_ok,
  input  logic [TS_W-1:0]        timestamp,
  output logic                   trip,
  output logic                   dac_zero,
  output logic                   ilk_out,
  output logic [NCH-1:0]         ch_fault,
  output logic [NCH*TS_W-1:0]    ch_time,
  output logic [NCH*VAL_W-1:0]   ch_value,
  output logic [N_EVT*IDX_W-1:0] evt_ch,
  output logic [N_EVT*TS_W-1:0]  evt_dt,
  output logic [CNT_W-1:0]       evt_cnt
);
  localparam int EXT_IDX = NCH - 1;

  logic [1:0]             rst_sync;
  logic                   rst_q;
  logic [NCH-1:0]         raw;
  logic [NCH*VAL_W-1:0]   cap_val;
  logic [NCH-1:0]         newhit;
  logic                   clr_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  for (genvar i = 0; i < N_RF; i++) begin : g_rf
    ilk_rf_det #(.W(RF_W)) u_det (
      .sample (rf_sample[i*RF_W +: RF_W]),
      .valid  (rf_valid[i]),
      .thresh (rf_thresh[i*RF_W +: RF_W]),
      .hit    (raw[i])
    );
    assign cap_val[i*VAL_W +: VAL_W] = VAL_W'($signed(rf_sample[i*RF_W +: RF_W]));
  end

  for (genvar j = 0; j < N_BB; j++) begin : g_bb
    ilk_bb_det #(.W(BB_W)) u_det (
      .value (bb_value[j*BB_W +: BB_W]),
      .valid (bb_valid[j]),
      .lo    (bb_lo[j*BB_W +: BB_W]),
      .hi    (bb_hi[j*BB_W +: BB_W]),
      .hit   (raw[N_RF + j])
    );
    assign cap_val[(N_RF+j)*VAL_W +: VAL_W] = VAL_W'(bb_value[j*BB_W +: BB_W]);
  end

  assign raw[EXT_IDX] = ~ext_ok;
  assign cap_val[EXT_IDX*VAL_W +: VAL_W] = '0;

  assign clr_eff = clr && (raw == '0);
  assign newhit  = clr_eff ? '0 : (raw & ~ch_fault);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ilk_ch_latch #(.TS_W(TS_W), .VAL_W(VAL_W)) u_latch (
      .clk    (clk),
      .rst_n  (rst_q),
      .hit    (raw[c]),
      .clr    (clr_eff),
      .ts     (timestamp),
      .val    (cap_val[c*VAL_W +: VAL_W]),
      .flag_q (ch_fault[c]),
      .ts_q   (ch_time[c*TS_W +: TS_W]),
      .val_q  (ch_value[c*VAL_W +: VAL_W])
    );
  end

  ilk_evt_seq #(.NCH(NCH), .N_EVT(N_EVT), .TS_W(TS_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_q),
    .clr     (clr_eff),
    .newhit  (newhit),
    .ts      (timestamp),
    .evt_ch  (evt_ch),
    .evt_dt  (evt_dt),
    .evt_cnt (evt_cnt)
  );

  assign trip     = |ch_fault;
  assign dac_zero = trip;
  assign ilk_out  = ~trip;

  // R5
  ext_trip_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !ext_ok |=> (trip && !ilk_out));

  // R9
  evt_flag_agree_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (evt_cnt == '0) == (ch_fault == '0));

  // R8
  clr_blocked_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (clr && (raw != '0)) |=> trip);
endmodule

// File: tb/ilk_aggregator_bench.sv
module ilk_aggregator_bench;
  localparam int NRF = 9, NBB = 8, RW = 16, BW = 12, TW = 32, NE = 10;
  localparam int NC = NRF + NBB + 1, VW = 16, IW = 5, CW = 4;

  logic clk = 1'b0;
  logic rst_n, clr, ext_ok;
  logic [TW-1:0] ts;
  logic signed [RW-1:0] rf_s [NRF];
  logic [RW-1:0] rf_t [NRF];
  logic [NRF-1:0] rf_v;
  logic [BW-1:0] bb_x [NBB], bb_l [NBB], bb_h [NBB];
  logic [NBB-1:0] bb_v;

  logic [NRF*RW-1:0] rf_sample, rf_thresh;
  logic [NBB*BW-1:0] bb_value, bb_lo, bb_hi;
  logic trip, dac_zero, ilk_out;
  logic [NC-1:0] ch_fault;
  logic [NC*TW-1:0] ch_time;
  logic [NC*VW-1:0] ch_value;
  logic [NE*IW-1:0] evt_ch;
  logic [NE*TW-1:0] evt_dt;
  logic [CW-1:0] evt_cnt;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NRF; i++) begin
      rf_sample[i*RW +: RW] = rf_s[i];
      rf_thresh[i*RW +: RW] = rf_t[i];
    end
    for (int j = 0; j < NBB; j++) begin
      bb_value[j*BW +: BW] = bb_x[j];
      bb_lo[j*BW +: BW]    = bb_l[j];
      bb_hi[j*BW +: BW]    = bb_h[j];
    end
  end

  ilk_aggregator u_ilk_aggregator (
    .clk(clk), .rst_n(rst_n), .clr(clr), .rf_sample(rf_sample), .rf_valid(rf_v),
    .rf_thresh(rf_thresh), .bb_value(bb_value), .bb_valid(bb_v), .bb_lo(bb_lo),
    .bb_hi(bb_hi), .ext_ok(ext_ok), .timestamp(ts), .trip(trip), .dac_zero(dac_zero),
    .ilk_out(ilk_out), .ch_fault(ch_fault), .ch_time(ch_time), .ch_value(ch_value),
    .evt_ch(evt_ch), .evt_dt(evt_dt), .evt_cnt(evt_cnt)
  );

  int n_chk = 0, n_fail = 0;
  bit mf [NC];
  logic [TW-1:0] mts [NC];
  logic [VW-1:0] mval [NC];
  int mev [NE];
  logic [TW-1:0] mdt [NE];
  int mcnt;
  logic [TW-1:0] mt0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < NC; c++) begin mf[c] = 0; mts[c] = '0; mval[c] = '0; end
    for (int k = 0; k < NE; k++) begin mev[k] = 0; mdt[k] = '0; end
    mcnt = 0; mt0 = '0;
  endtask

  task automatic compare_all(string req);
    logic [NC-1:0] ef;
    bit any;
    any = 0;
    for (int c = 0; c < NC; c++) begin ef[c] = mf[c]; any |= mf[c]; end
    chk("R6", "trip", trip, any);
    chk("R6", "dac_zero", dac_zero, any);
    chk("R6", "ilk_out", ilk_out, !any);
    chk(req, "ch_fault", ch_fault, ef);
    for (int c = 0; c < NC; c++) begin
      chk("R7", $sformatf("time[%0d]", c), ch_time[c*TW +: TW], mts[c]);
      chk("R7", $sformatf("value[%0d]", c), ch_value[c*VW +: VW], mval[c]);
    end
    chk("R11", "evt_cnt", evt_cnt, mcnt);
    for (int k = 0; k < NE; k++) begin
      chk("R9", $sformatf("evt_ch[%0d]", k), evt_ch[k*IW +: IW], mev[k]);
      chk("R10", $sformatf("evt_dt[%0d]", k), evt_dt[k*TW +: TW], mdt[k]);
    end
  endtask

  task automatic tick(string req);
    bit raw [NC];
    logic [VW-1:0] v [NC];
    bit none;
    none = 1;
    for (int i = 0; i < NRF; i++) begin
      int a;
      a = rf_s[i];
      if (a < 0) a = -a;
      raw[i] = rf_v[i] && (a > int'(rf_t[i]));
      v[i] = rf_s[i];
    end
    for (int j = 0; j < NBB; j++) begin
      raw[NRF+j] = bb_v[j] && ((bb_x[j] < bb_l[j]) || (bb_x[j] > bb_h[j]));
      v[NRF+j] = {4'b0, bb_x[j]};
    end
    raw[NC-1] = !ext_ok;
    v[NC-1] = '0;
    for (int c = 0; c < NC; c++) if (raw[c]) none = 0;
    if (clr && none) model_clear();
    else begin
      for (int c = 0; c < NC; c++) begin
        if (raw[c] && !mf[c]) begin
          mf[c] = 1; mts[c] = ts; mval[c] = v[c];
          if (mcnt < NE) begin
            if (mcnt == 0) mt0 = ts;
            mev[mcnt] = c; mdt[mcnt] = ts - mt0; mcnt++;
          end
        end
      end
    end
    @(posedge clk);
    #1;
    ts = ts + 1;
    rf_v = '0; bb_v = '0; clr = 1'b0;
    compare_all(req);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; ext_ok = 1'b1; ts = 32'd1000; rf_v = '0; bb_v = '0;
    for (int i = 0; i < NRF; i++) begin rf_s[i] = '0; rf_t[i] = RW'(1000 + 37*i); end
    for (int j = 0; j < NBB; j++) begin bb_x[j] = 12'd500; bb_l[j] = BW'(100 + j); bb_h[j] = BW'(3000 - j); end
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1");
    rst_n = 1'b1;
    repeat (3) tick("R1");

    // R3: out-of-range data without strobes
    for (int i = 0; i < NRF; i++) rf_s[i] = 16'sh8000;
    for (int j = 0; j < NBB; j++) bb_x[j] = 12'hFFF;
    tick("R3");
    for (int i = 0; i < NRF; i++) rf_s[i] = '0;
    for (int j = 0; j < NBB; j++) bb_x[j] = 12'd500;

    // R2: magnitude boundary per RF channel, both signs
    for (int i = 0; i < NRF; i++) begin
      rf_s[i] = $signed(rf_t[i]); rf_v[i] = 1'b1; tick("R2");
      rf_s[i] = -$signed(rf_t[i]); rf_v[i] = 1'b1; tick("R2");
      rf_s[i] = (i % 2 == 1) ? $signed(rf_t[i]) + 16'sd1 : -$signed(rf_t[i]) - 16'sd1;
      rf_v[i] = 1'b1; tick("R2");
      rf_v[i] = 1'b1; rf_s[i] = 16'sd5; tick("R7");
      rf_s[i] = '0; clr = 1'b1; tick("R8");
    end
    rf_t[4] = 16'h7FFF; rf_s[4] = 16'sh8000; rf_v[4] = 1'b1; tick("R2");
    rf_s[4] = '0; rf_t[4] = 16'd1148; clr = 1'b1; tick("R8");

    // R4: window boundaries per baseband channel
    for (int j = 0; j < NBB; j++) begin
      bb_x[j] = bb_l[j]; bb_v[j] = 1'b1; tick("R4");
      bb_x[j] = bb_h[j]; bb_v[j] = 1'b1; tick("R4");
      bb_x[j] = bb_l[j] - 12'd1; bb_v[j] = 1'b1; tick("R4");
      clr = 1'b1; tick("R8");
      bb_x[j] = bb_h[j] + 12'd1; bb_v[j] = 1'b1; tick("R4");
      bb_x[j] = 12'd500; clr = 1'b1; tick("R8");
    end
    bb_l[2] = '0; bb_h[2] = 12'hFFF;
    bb_x[2] = '0; bb_v[2] = 1'b1; tick("R4");
    bb_x[2] = 12'hFFF; bb_v[2] = 1'b1; tick("R4");
    bb_x[2] = 12'd500; bb_l[2] = 12'd102; bb_h[2] = 12'd2998;

    // R5 / R8: fail-safe external line, clear blocked while active
    ext_ok = 1'b0; tick("R5");
    tick("R5");
    clr = 1'b1; tick("R8");
    ext_ok = 1'b1; tick("R8");
    clr = 1'b1; tick("R8");

    // R9 / R10 / R11: ordering, delays, list overflow
    rf_s[5] = 16'sd4000; rf_v[5] = 1'b1;
    rf_s[2] = -16'sd4000; rf_v[2] = 1'b1;
    bb_x[3] = 12'd4000; bb_v[3] = 1'b1;
    tick("R9");
    tick("R9");
    rf_s[0] = 16'sd3000; rf_v[0] = 1'b1; tick("R10");
    for (int i = 0; i < NRF; i++) begin rf_s[i] = 16'sd30000; rf_v[i] = 1'b1; end
    for (int j = 0; j < NBB; j++) begin bb_x[j] = 12'd4090; bb_v[j] = 1'b1; end
    ext_ok = 1'b0;
    tick("R11");
    ext_ok = 1'b1;
    for (int i = 0; i < NRF; i++) rf_s[i] = '0;
    for (int j = 0; j < NBB; j++) bb_x[j] = 12'd500;
    tick("R11");
    clr = 1'b1; tick("R8");
    tick("R1");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule